// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block runs whole command transactions to a small serial EEPROM over a three-wire link. The link has a chip select, a serial clock and a data line in each direction. A host loads a command code, an address and a write byte, then pulses a go strobe. The block raises chip select and builds the serial frame: a start bit, a two-bit opcode, any padding slot and the address. It shifts the frame out with the most significant bit first and changes the data line only while the serial clock is low. For a read, it collects the returned byte into a register that the host can see.

The array may hold 128 or 256 bytes, which gives an address field of 7 or 9 bits. A runtime divider sets the speed of the serial clock. For commands that change the array, the master keeps chip select high after the last bit and watches the device data line until the device reports ready. A timeout counter ends the wait with an error flag if ready never comes. Completion is marked by a one-cycle done pulse in the same cycle that chip select and busy fall.

Top module: `ee3w_cmd_master`

## Requirements
- R1: While reset is held, cs_o, sk_o, di_o, busy_o, done_o and err_o are low and rdata_o is zero.
- R2: cs_o rises in the cycle after an accepted go. The first sk_o rise follows 2*(div_i+1) cycles later. sk_o is high only while cs_o is high, and cs_o stays high until the transaction completes.
- R3: Each sk_o half period lasts div_i+1 system clock cycles. di_o changes only while sk_o is low.
- R4: Every frame begins with a start bit of 1 and then a two-bit opcode: READ 10, WRITE 01, ERASE 11, and 00 for the four global commands. In a global command, the two most significant address-field bits choose the action: write-enable 11, write-disable 00, erase-all 10, write-all 01. The remaining address-field bits are 0. All fields go out MSB first.
- R5: The address field is 7 bits when ARRAY_BYTES is 128 and 9 bits when it is 256. The number of sk_o rising edges per frame is 3+A for ERASE and the write-enable, write-disable and erase-all commands, 11+A for WRITE and write-all, and 12+A for READ, where A is the address width.
- R6: A READ places one null bit (0) between the opcode and the address MSB. It then runs 8 data slots. do_i is sampled at each sk_o rising edge and shifted into rdata_o MSB first.
- R7: WRITE and write-all send the 8 bits of wdata_i, MSB first, directly after the address field.
- R8: cmd_i encodes READ=0, WRITE=1, ERASE=2, write-enable=3, write-disable=4, erase-all=5, write-all=6. A go with code 7 is ignored, and busy_o and cs_o stay low.
- R9: busy_o rises in the cycle after an accepted go and falls in the cycle cs_o drops. done_o pulses for exactly that cycle. A go that arrives while busy_o is high is ignored.
- R10: After the last bit of WRITE, ERASE, erase-all or write-all, cs_o stays high and sk_o stays low. The transaction completes only once do_i reads 1.
- R11: If do_i stays 0 for TIMEOUT cycles of that wait, the transaction completes with err_o set. err_o clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial clock half period minus one, in system cycles |
| go_i | input | 1 | Start strobe, one cycle |
| cmd_i | input | 3 | Command code |
| addr_i | input | ADDR_W | Array address (7 or 9 bits) |
| wdata_i | input | 8 | Byte for WRITE and write-all |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready wait timed out on the last command |
| rdata_o | output | 8 | Byte returned by the last READ |
| cs_o | output | 1 | Serial chip select |
| sk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data toward the EEPROM |
| do_i | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The hardest states to reach are the ready-wait timeout and a go strobe that arrives in the middle of a frame. The bench uses a behavioural array that holds its data line low for a programmable number of cycles after every committed write. Setting that hold longer than the block's TIMEOUT forces the error path, and the bench then lets the array finish before the next command. The bench also issues a second go part-way through a read, then shows through later reads that neither the returned byte nor the stored data was disturbed. Sweeps over every address of the small array, plus a second instance with the 9-bit address, confirm frame lengths and data order for each command.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    typedef enum logic [2:0] {
        CMD_READ      = 3'd0,
        CMD_WRITE     = 3'd1,
        CMD_ERASE     = 3'd2,
        CMD_WREN      = 3'd3,
        CMD_WRDIS     = 3'd4,
        CMD_ERASE_ALL = 3'd5,
        CMD_WRITE_ALL = 3'd6
    } ee_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_POLL  = 3'd4
    } seq_st_e;

    // address field width for a given array size
    function automatic int addr_bits(input int bytes);
        return (bytes > 128) ? 9 : 7;
    endfunction

endpackage

// File: rtl/ee3w_sclk_gen.sv
module ee3w_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    // one tick per half period of div_i+1 cycles
    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        cnt_d  = (run_i && !tick_o) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ee3w_frame_build.sv
module ee3w_frame_build import ee3w_pkg::*; #(
    parameter int ADDR_W  = 7,
    parameter int FRAME_W = 12 + ADDR_W,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [2:0]         cmd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [7:0]         wdata_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [CNT_W-1:0]   nbits_o,
    output logic               rd_o,
    output logic               wt_o,
    output logic               ok_o
);

    localparam int PAD_W = ADDR_W - 2;

    logic [FRAME_W-1:0] v;

    always_comb begin
        v     = '0;
        nbits_o = '0;
        rd_o  = 1'b0;
        wt_o  = 1'b0;
        ok_o  = 1'b1;
        case (cmd_i)
            CMD_READ: begin
                v = FRAME_W'({3'b110, 1'b0, addr_i, 8'h00});
                nbits_o = CNT_W'(12 + ADDR_W);
                rd_o = 1'b1;
            end
            CMD_WRITE: begin
                v = FRAME_W'({3'b101, addr_i, wdata_i});
                nbits_o = CNT_W'(11 + ADDR_W);
                wt_o = 1'b1;
            end
            CMD_ERASE: begin
                v = FRAME_W'({3'b111, addr_i});
                nbits_o = CNT_W'(3 + ADDR_W);
                wt_o = 1'b1;
            end
            CMD_WREN: begin
                v = FRAME_W'({3'b100, 2'b11, {PAD_W{1'b0}}});
                nbits_o = CNT_W'(3 + ADDR_W);
            end
            CMD_WRDIS: begin
                v = FRAME_W'({3'b100, 2'b00, {PAD_W{1'b0}}});
                nbits_o = CNT_W'(3 + ADDR_W);
            end
            CMD_ERASE_ALL: begin
                v = FRAME_W'({3'b100, 2'b10, {PAD_W{1'b0}}});
                nbits_o = CNT_W'(3 + ADDR_W);
                wt_o = 1'b1;
            end
            CMD_WRITE_ALL: begin
                v = FRAME_W'({3'b100, 2'b01, {PAD_W{1'b0}}, wdata_i});
                nbits_o = CNT_W'(11 + ADDR_W);
                wt_o = 1'b1;
            end
            default: ok_o = 1'b0;
        endcase
        // left-align so the first bit to send sits at the MSB
        frame_o = v << (CNT_W'(FRAME_W) - nbits_o);
    end

endmodule

// File: rtl/ee3w_cmd_master.sv
module ee3w_cmd_master import ee3w_pkg::*; #(
    parameter  int ARRAY_BYTES = 128,
    parameter  int DIV_W       = 8,
    parameter  int TIMEOUT     = 4096,
    localparam int ADDR_W      = addr_bits(ARRAY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              go_i,
    input  logic [2:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [7:0]        rdata_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    input  logic              do_i
);

    localparam int FRAME_W = 12 + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int TO_W    = $clog2(TIMEOUT + 1);

    typedef struct packed {
        seq_st_e            st;
        logic               cs;
        logic               sk;
        logic               di;
        logic               busy;
        logic               done;
        logic               err;
        logic               rd;
        logic               wt;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   nbits;
        logic [CNT_W-1:0]   slot;
        logic [7:0]         rdata;
        logic [TO_W-1:0]    to_cnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [FRAME_W-1:0] f_frame;
    logic [CNT_W-1:0]   f_nbits;
    logic               f_rd, f_wt, f_ok;
    logic               tick, run, fin;

    ee3w_frame_build #(
        .ADDR_W (ADDR_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) i_frame (
        .cmd_i  (cmd_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .frame_o(f_frame),
        .nbits_o(f_nbits),
        .rd_o   (f_rd),
        .wt_o   (f_wt),
        .ok_o   (f_ok)
    );

    assign run = (c_q.st == ST_SETUP) || (c_q.st == ST_LOW) || (c_q.st == ST_HIGH);

    ee3w_sclk_gen #(.DIV_W(DIV_W)) i_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .div_i (div_i),
        .tick_o(tick)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        fin      = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (go_i && f_ok) begin
                    c_d.st     = ST_SETUP;
                    c_d.cs     = 1'b1;
                    c_d.busy   = 1'b1;
                    c_d.err    = 1'b0;
                    c_d.frame  = f_frame;
                    c_d.nbits  = f_nbits;
                    c_d.rd     = f_rd;
                    c_d.wt     = f_wt;
                    c_d.slot   = '0;
                    c_d.to_cnt = '0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    c_d.st    = ST_LOW;
                    c_d.di    = c_q.frame[FRAME_W-1];
                    c_d.frame = c_q.frame << 1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    c_d.st = ST_HIGH;
                    c_d.sk = 1'b1;
                    if (c_q.rd && (c_q.slot >= c_q.nbits - CNT_W'(8)))
                        c_d.rdata = {c_q.rdata[6:0], do_i};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    c_d.sk = 1'b0;
                    if (c_q.slot == c_q.nbits - 1'b1) begin
                        c_d.di = 1'b0;
                        if (c_q.wt) c_d.st = ST_POLL;
                        else        fin = 1'b1;
                    end else begin
                        c_d.st    = ST_LOW;
                        c_d.di    = c_q.frame[FRAME_W-1];
                        c_d.frame = c_q.frame << 1;
                        c_d.slot  = c_q.slot + 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (do_i) begin
                    fin = 1'b1;
                end else if (c_q.to_cnt == TO_W'(TIMEOUT - 1)) begin
                    fin     = 1'b1;
                    c_d.err = 1'b1;
                end else begin
                    c_d.to_cnt = c_q.to_cnt + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (fin) begin
            c_d.st   = ST_IDLE;
            c_d.cs   = 1'b0;
            c_d.sk   = 1'b0;
            c_d.di   = 1'b0;
            c_d.busy = 1'b0;
            c_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o  = c_q.busy;
    assign done_o  = c_q.done;
    assign err_o   = c_q.err;
    assign rdata_o = c_q.rdata;
    assign cs_o    = c_q.cs;
    assign sk_o    = c_q.sk;
    assign di_o    = c_q.di;

    AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o); // R2

    AST_DI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o)); // R3

    AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i)); // R9

    AST_DONE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cs_o && !busy_o && $past(cs_o))); // R9

    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o); // R11

    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_POLL) |-> (cs_o && !sk_o)); // R10

endmodule

// File: tb/test_ee3w_cmd_master.sv
`timescale 1ns/1ps

module ee3w_mem_model #(
    parameter int ADDR_W = 7,
    parameter int BYTES  = 128
) (
    input  logic clk,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  int   busy_len,
    output logic dout
);
    logic [7:0]  mem [BYTES];
    logic [31:0] bits;
    logic [1:0]  op, sel;
    logic [7:0]  dsh;
    logic        en, rd_on, psk;
    int          cnt, bcnt, frame_err;

    function automatic int idx(input logic [8:0] a);
        return int'(a) % BYTES;
    endfunction

    initial begin
        dout = 1'b1; bits = '0; op = '0; sel = '0; dsh = '0;
        en = 1'b0; rd_on = 1'b0; psk = 1'b0;
        cnt = 0; bcnt = 0; frame_err = 0;
        for (int i = 0; i < BYTES; i++) mem[i] = 8'h00;
    end

    always @(negedge clk) begin
        if (bcnt > 0) begin
            bcnt = bcnt - 1;
            if (bcnt == 0) dout = 1'b1;
        end
        if (!cs) begin
            cnt = 0; rd_on = 1'b0;
            dout = (bcnt == 0);
        end else if (sk && !psk) begin
            bits = {bits[30:0], di};
            cnt  = cnt + 1;
            if (cnt == 1 && !di) frame_err++;
            if (cnt == 3) op = bits[1:0];
            if (op == 2'b10 && cnt == 4 + ADDR_W) begin
                if (bits[ADDR_W]) frame_err++;
                dsh = mem[idx(9'(bits[ADDR_W-1:0]))];
                rd_on = 1'b1;
            end
            if (op == 2'b01 && cnt == 11 + ADDR_W && en) begin
                mem[idx(9'(bits[ADDR_W+7:8]))] = bits[7:0];
                dout = 1'b0; bcnt = busy_len;
            end
            if (op == 2'b11 && cnt == 3 + ADDR_W && en) begin
                mem[idx(9'(bits[ADDR_W-1:0]))] = 8'hFF;
                dout = 1'b0; bcnt = busy_len;
            end
            if (op == 2'b00 && cnt == 3 + ADDR_W) begin
                sel = bits[ADDR_W-1:ADDR_W-2];
                if (bits[ADDR_W-3:0] != '0) frame_err++;
                if (sel == 2'b11) en = 1'b1;
                if (sel == 2'b00) en = 1'b0;
                if (sel == 2'b10 && en) begin
                    for (int i = 0; i < BYTES; i++) mem[i] = 8'hFF;
                    dout = 1'b0; bcnt = busy_len;
                end
            end
            if (op == 2'b00 && sel == 2'b01 && cnt == 11 + ADDR_W && en) begin
                for (int i = 0; i < BYTES; i++) mem[i] = bits[7:0];
                dout = 1'b0; bcnt = busy_len;
            end
        end else if (!sk && psk && rd_on) begin
            dout = dsh[7];
            dsh  = {dsh[6:0], 1'b0};
        end
        psk = sk;
    end
endmodule

module test_ee3w_cmd_master;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] div;
    logic       go_s, go_b;
    logic [2:0] cmd;
    logic [8:0] addr;
    logic [7:0] wdata;
    int         busy_len;

    logic cs_s, sk_s, di_s, busy_s, done_s, err_s, do_s;
    logic cs_b, sk_b, di_b, busy_b, done_b, err_b, do_b;
    logic [7:0] rdata_s, rdata_b;

    logic big;
    logic cs_m, sk_m, di_m, busy_m, done_m, err_m;
    logic [7:0] rdata_m;

    int errs = 0, checks = 0;
    logic [7:0] exp_s [128];
    logic [7:0] exp_b [256];

    always #2 clk = ~clk;

    ee3w_cmd_master #(.ARRAY_BYTES(128), .DIV_W(8), .TIMEOUT(64)) i_ee3w_cmd_master (
        .clk(clk), .rst_n(rst_n), .div_i(div), .go_i(go_s), .cmd_i(cmd),
        .addr_i(addr[6:0]), .wdata_i(wdata), .busy_o(busy_s), .done_o(done_s),
        .err_o(err_s), .rdata_o(rdata_s), .cs_o(cs_s), .sk_o(sk_s), .di_o(di_s),
        .do_i(do_s));

    ee3w_cmd_master #(.ARRAY_BYTES(256), .DIV_W(8), .TIMEOUT(64)) i_ee3w_cmd_master_w9 (
        .clk(clk), .rst_n(rst_n), .div_i(div), .go_i(go_b), .cmd_i(cmd),
        .addr_i(addr), .wdata_i(wdata), .busy_o(busy_b), .done_o(done_b),
        .err_o(err_b), .rdata_o(rdata_b), .cs_o(cs_b), .sk_o(sk_b), .di_o(di_b),
        .do_i(do_b));

    ee3w_mem_model #(.ADDR_W(7), .BYTES(128)) i_mdl_s (
        .clk(clk), .cs(cs_s), .sk(sk_s), .di(di_s), .busy_len(busy_len), .dout(do_s));
    ee3w_mem_model #(.ADDR_W(9), .BYTES(256)) i_mdl_b (
        .clk(clk), .cs(cs_b), .sk(sk_b), .di(di_b), .busy_len(busy_len), .dout(do_b));

    assign cs_m    = big ? cs_b    : cs_s;
    assign sk_m    = big ? sk_b    : sk_s;
    assign di_m    = big ? di_b    : di_s;
    assign busy_m  = big ? busy_b  : busy_s;
    assign done_m  = big ? done_b  : done_s;
    assign err_m   = big ? err_b   : err_s;
    assign rdata_m = big ? rdata_b : rdata_s;

    // link monitor
    int  cyc = 0, last_rise = 0, cs_rise = 0, rises = 0, frame_rises = 0;
    int  gap_err = 0, cs_err = 0, di_err = 0;
    logic p_sk = 1'b0, p_cs = 1'b0, p_di = 1'b0, first = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cs_m && !p_cs) begin cs_rise = cyc; rises = 0; first = 1'b1; end
        if (sk_m && !p_sk) begin
            if (first) begin
                if (cyc - cs_rise != 2 * (int'(div) + 1)) cs_err++;
                first = 1'b0;
            end else if (cyc - last_rise != 2 * (int'(div) + 1)) gap_err++;
            last_rise = cyc;
            rises++;
        end
        if (sk_m && p_sk && di_m != p_di) di_err++;
        if (!cs_m && p_cs) frame_rises = rises;
        p_sk = sk_m; p_cs = cs_m; p_di = di_m;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11);
    endfunction

    function automatic int frame_len(input logic [2:0] c, input bit b);
        int aw = b ? 9 : 7;
        case (c)
            3'd0:          return 12 + aw;
            3'd1, 3'd6:    return 11 + aw;
            default:       return 3 + aw;
        endcase
    endfunction

    task automatic run(input bit b, input logic [2:0] c, input int a, input logic [7:0] d,
                       input bit expect_ready);
        @(negedge clk);
        big = b; cmd = c; addr = 9'(a); wdata = d;
        if (b) go_b = 1'b1; else go_s = 1'b1;
        @(negedge clk);
        go_s = 1'b0; go_b = 1'b0;
        chk(busy_m && cs_m, "R9 busy after go", int'(busy_m), 1);
        while (!done_m) @(negedge clk);
        chk(!busy_m && !cs_m, "R9 done with deselect", int'(cs_m), 0);
        if (expect_ready && (c == 3'd1 || c == 3'd2 || c == 3'd5 || c == 3'd6))
            chk((b ? i_mdl_b.bcnt : i_mdl_s.bcnt) == 0, "R10 waited for ready",
                b ? i_mdl_b.bcnt : i_mdl_s.bcnt, 0);
        @(negedge clk);
        chk(frame_rises == frame_len(c, b), "R5 frame clock count", frame_rises, frame_len(c, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R9 watchdog: actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; div = 8'd1; go_s = 1'b0; go_b = 1'b0; cmd = '0; addr = '0;
        wdata = '0; busy_len = 5; big = 1'b0;
        for (int i = 0; i < 128; i++) exp_s[i] = 8'h00;
        for (int i = 0; i < 256; i++) exp_b[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!cs_s && !sk_s && !di_s && !busy_s && !done_s && !err_s && rdata_s == 8'h00,
            "R1 reset state", {cs_s, sk_s, busy_s, err_s}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reserved code 7 is ignored
        cmd = 3'd7; go_s = 1'b1;
        @(negedge clk); go_s = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy_s && !cs_s, "R8 code 7 ignored", int'(busy_s), 0);

        // R4 write-enable on the small array
        run(1'b0, 3'd3, 0, 8'h00, 1'b1);

        // R7 exhaustive writes, then R6 exhaustive reads
        div = 8'd0;
        for (int a = 0; a < 128; a++) begin
            run(1'b0, 3'd1, a, pat(a), 1'b1);
            exp_s[a] = pat(a);
        end
        for (int a = 0; a < 128; a++) begin
            run(1'b0, 3'd0, a, 8'h00, 1'b1);
            chk(rdata_s == exp_s[a], "R6 read data", rdata_s, exp_s[a]);
        end

        // R4 erase at a slower clock
        div = 8'd2;
        run(1'b0, 3'd2, 5, 8'h00, 1'b1); exp_s[5] = 8'hFF;
        run(1'b0, 3'd0, 5, 8'h00, 1'b1);
        chk(rdata_s == 8'hFF, "R4 erase", rdata_s, 8'hFF);

        // R4 write-disable blocks a later write
        run(1'b0, 3'd4, 0, 8'h00, 1'b1);
        run(1'b0, 3'd1, 6, 8'h11, 1'b1);
        run(1'b0, 3'd0, 6, 8'h00, 1'b1);
        chk(rdata_s == exp_s[6], "R4 write-disable honoured", rdata_s, exp_s[6]);
        run(1'b0, 3'd3, 0, 8'h00, 1'b1);

        // R4 erase-all, R7 write-all
        div = 8'd0;
        run(1'b0, 3'd5, 0, 8'h00, 1'b1);
        for (int a = 0; a < 128; a += 9) begin
            run(1'b0, 3'd0, a, 8'h00, 1'b1);
            chk(rdata_s == 8'hFF, "R4 erase-all", rdata_s, 8'hFF);
        end
        run(1'b0, 3'd6, 0, 8'h3C, 1'b1);
        for (int a = 0; a < 128; a++) begin
            exp_s[a] = 8'h3C;
            run(1'b0, 3'd0, a, 8'h00, 1'b1);
            chk(rdata_s == 8'h3C, "R7 write-all", rdata_s, 8'h3C);
        end
        run(1'b0, 3'd1, 10, 8'hA5, 1'b1); exp_s[10] = 8'hA5;

        // R9 go while busy is ignored
        div = 8'd1;
        @(negedge clk);
        big = 1'b0; cmd = 3'd0; addr = 9'd10; go_s = 1'b1;
        @(negedge clk); go_s = 1'b0;
        repeat (8) @(negedge clk);
        cmd = 3'd1; addr = 9'd10; wdata = 8'h00; go_s = 1'b1;
        @(negedge clk); go_s = 1'b0;
        while (!done_s) @(negedge clk);
        chk(rdata_s == 8'hA5, "R9 mid-frame go ignored", rdata_s, 8'hA5);
        repeat (4) @(negedge clk);
        chk(!busy_s, "R9 no second transaction", int'(busy_s), 0);
        run(1'b0, 3'd0, 10, 8'h00, 1'b1);
        chk(rdata_s == 8'hA5, "R9 array untouched", rdata_s, 8'hA5);

        // R11 timeout, then recovery
        busy_len = 500;
        run(1'b0, 3'd1, 20, 8'h77, 1'b0); exp_s[20] = 8'h77;
        chk(err_s == 1'b1, "R11 timeout flag", int'(err_s), 1);
        repeat (600) @(negedge clk);
        busy_len = 5;
        run(1'b0, 3'd0, 20, 8'h00, 1'b1);
        chk(err_s == 1'b0, "R11 flag cleared", int'(err_s), 0);
        chk(rdata_s == 8'h77, "R11 read after timeout", rdata_s, 8'h77);

        // R5 nine-bit address instance
        div = 8'd3;
        run(1'b1, 3'd3, 0, 8'h00, 1'b1);
        for (int k = 0; k < 8; k++) begin
            int a = (k * 73 + 1) % 256;
            run(1'b1, 3'd1, a, pat(a + 3), 1'b1);
            exp_b[a] = pat(a + 3);
        end
        run(1'b1, 3'd1, 255, 8'hC3, 1'b1); exp_b[255] = 8'hC3;
        for (int k = 0; k < 8; k++) begin
            int a = (k * 73 + 1) % 256;
            run(1'b1, 3'd0, a, 8'h00, 1'b1);
            chk(rdata_b == exp_b[a], "R5 wide read", rdata_b, exp_b[a]);
        end
        run(1'b1, 3'd0, 255, 8'h00, 1'b1);
        chk(rdata_b == 8'hC3, "R5 top address", rdata_b, 8'hC3);
        run(1'b1, 3'd2, 74, 8'h00, 1'b1);
        run(1'b1, 3'd0, 74, 8'h00, 1'b1);
        chk(rdata_b == 8'hFF, "R4 wide erase", rdata_b, 8'hFF);

        chk(gap_err == 0, "R3 half period", gap_err, 0);
        chk(di_err == 0, "R3 data steady while clock high", di_err, 0);
        chk(cs_err == 0, "R2 select lead", cs_err, 0);
        chk(i_mdl_s.frame_err + i_mdl_b.frame_err == 0, "R4 R6 frame fields",
            i_mdl_s.frame_err + i_mdl_b.frame_err, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule